// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the host write cycles that reach a dual-bank NOR flash and turns the protected multi-write command sequences into single-cycle operation launches. It watches the word address, the data bus and an asynchronous active-low write strobe. It brings the strobe into the clock domain and detects its edges. The address is taken when the strobe falls and the data when it rises. From these cycles it recognises word program, sector erase, block erase, chip erase, erase suspend, erase resume, the parameter-query mode and the identifier-query mode.

Once a sequence is accepted, the decoder issues a one-cycle start pulse with the operation kind, the target address and the program data. It then marks the affected bank or banks busy until the array engine returns a done pulse. While an operation runs, the decoder drops all writes except the suspend and resume commands during a sector or block erase. A write-protect input guards the lowest region of the large bank, and a synchronous reset returns everything to read mode.

Bank 1 is the large bank and holds the word addresses below `BANK_SPLIT` (0xC0000 by default). Bank 2 holds the rest. The protected region is the words below `PROT_LIMIT` (0x2000 by default).

Top module: `fcd_top`

## Requirements
- R1: A program is accepted after the prefix data AAH at key 555H, then 55H at key 2AAH, then A0H at key 555H. The key is the low 11 address bits. The fourth write then gives start_kind 0, start_addr equal to that write's address, and start_data equal to its full 16 data bits. start_pulse is high for exactly one cycle.
- R2: An erase needs six writes: AAH@555H, 55H@2AAH, 80H@555H, AAH@555H, 55H@2AAH, then the command. Command 30H at any address gives start_kind 1 with the address rounded down to 2K words. Command 50H gives start_kind 2, rounded down to 32K words. Command 10H at key 555H gives start_kind 3, start_addr 0, and both banks busy.
- R3: The address of a write is the one present when the strobe falls. A later change of address while the strobe is low has no effect.
- R4: start_pulse, suspend_pulse and resume_pulse go high on the third rising clock edge after the write strobe returns high.
- R5: bank_busy bit 0 marks bank 1 and bit 1 marks bank 2. A launch sets the bit of the bank that holds the target address. The bit stays set until op_done is sampled high, and it clears on that clock edge.
- R6: While a program or chip erase is busy, every write is ignored. This includes full command sequences, B0H, 30H and F0H: no pulse fires and no mode changes.
- R7: While a sector or block erase is busy, B0H at any address suspends it. This raises suspend_pulse and sets erase_suspended. 30H while suspended resumes it, raising resume_pulse and clearing erase_suspended. op_done is ignored while suspended, and all other commands are dropped.
- R8: A write that does not match the next expected cycle of a sequence returns the decoder to read mode. The writes that follow then launch nothing until a new prefix starts.
- R9: Data bits 15 to 8 are ignored on every command cycle.
- R10: AAH@555H, 55H@2AAH, 98H@555H sets cfi_mode. The same prefix with 88H@555H sets secid_mode. Entering one mode clears the other. A single F0H write at any address while idle clears both.
- R11: With wp_n low, a chip erase is ignored. A program or sector erase whose aligned target is below 0x2000 is ignored, and so is a block erase whose block starts below 0x2000. Targets at or above 0x2000 are accepted.
- R12: rst high clears every output, ends a busy or suspended operation, and drops a partly entered sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Host word address |
| bus_data | input | 16 | Host write data |
| we_n | input | 1 | Asynchronous active-low write strobe |
| wp_n | input | 1 | Write-protect, low protects the bottom region |
| op_done | input | 1 | Array engine finished the running operation |
| start_pulse | output | 1 | One-cycle operation launch |
| start_kind | output | 2 | 0 program, 1 sector, 2 block, 3 chip erase |
| start_addr | output | 20 | Target address, aligned for erases |
| start_data | output | 16 | Program data (0 for erases) |
| bank_busy | output | 2 | Per-bank busy flags |
| suspend_pulse | output | 1 | One-cycle erase suspend request |
| resume_pulse | output | 1 | One-cycle erase resume request |
| erase_suspended | output | 1 | Running erase is suspended |
| cfi_mode | output | 1 | Parameter-query mode active |
| secid_mode | output | 1 | Identifier-query mode active |

## Verification
The strobe passes through three synchronising flops. A falling strobe latches the address on the third clock edge, and a rising strobe acts on the third clock edge, so every launch, suspend, resume and mode change shows at the outputs just after that edge. The bench's write task raises the strobe on a falling clock edge, counts three rising edges, and samples one time step later. This pins the pulse to its exact cycle. bank_busy is checked on the falling edge that follows the one cycle in which op_done is high. The no-effect requirements are judged by sampling the pulse, busy and mode outputs at the same due cycle of each dropped write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int CMD_W  = 8;

    localparam logic [CMD_W-1:0] C_UNLOCK1 = 8'hAA;
    localparam logic [CMD_W-1:0] C_UNLOCK2 = 8'h55;
    localparam logic [CMD_W-1:0] C_PROGRAM = 8'hA0;
    localparam logic [CMD_W-1:0] C_ERASE   = 8'h80;
    localparam logic [CMD_W-1:0] C_SECTOR  = 8'h30;
    localparam logic [CMD_W-1:0] C_BLOCK   = 8'h50;
    localparam logic [CMD_W-1:0] C_CHIP    = 8'h10;
    localparam logic [CMD_W-1:0] C_SUSPEND = 8'hB0;
    localparam logic [CMD_W-1:0] C_RESUME  = 8'h30;
    localparam logic [CMD_W-1:0] C_CFI     = 8'h98;
    localparam logic [CMD_W-1:0] C_SECID   = 8'h88;
    localparam logic [CMD_W-1:0] C_EXIT    = 8'hF0;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLK   = 2'd2,
        OP_CHIP  = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E3, SQ_E4, SQ_E5
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [1:0]        banks;
    } launch_t;

    typedef struct packed {
        logic suspend;
        logic resume;
        logic cfi_on;
        logic sec_on;
        logic exit_modes;
    } ctl_t;

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                     input int unsigned w);
        return a & ~((ADDR_W'(1) << w) - ADDR_W'(1));
    endfunction

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture
    import fcd_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr
);
    logic [STAGES-1:0] sync_q;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], we_n};
    end

    assign fall   =  sync_q[STAGES-1] & ~sync_q[STAGES-2];
    assign wr_evt = ~sync_q[STAGES-1] &  sync_q[STAGES-2];

    always_ff @(posedge clk) begin
        if (rst)       wr_addr <= '0;
        else if (fall) wr_addr <= bus_addr;
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int                KEY_W      = 11,
    parameter int                SECT_W     = 11,
    parameter int                BLK_W      = 15,
    parameter logic [ADDR_W-1:0] BANK_SPLIT = 20'hC0000,
    parameter logic [ADDR_W-1:0] PROT_LIMIT = 20'h02000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_n,
    input  logic              busy,
    input  op_kind_e          busy_kind,
    input  logic              suspended,
    output launch_t           launch,
    output ctl_t              ctl
);
    localparam logic [KEY_W-1:0] KEY_A = KEY_W'(12'h555);
    localparam logic [KEY_W-1:0] KEY_B = KEY_W'(12'h2AA);

    seq_state_e        st, nxt;
    logic [CMD_W-1:0]  cmd;
    logic              at_a, at_b;
    logic [ADDR_W-1:0] sect_base, blk_base;

    assign cmd       = wr_data[CMD_W-1:0];
    assign at_a      = wr_addr[KEY_W-1:0] == KEY_A;
    assign at_b      = wr_addr[KEY_W-1:0] == KEY_B;
    assign sect_base = align_down(wr_addr, SECT_W);
    assign blk_base  = align_down(wr_addr, BLK_W);

    function automatic logic [1:0] bank_of(input logic [ADDR_W-1:0] a);
        return (a < BANK_SPLIT) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic guarded(input logic [ADDR_W-1:0] a, input logic wp);
        return !wp && (a < PROT_LIMIT);
    endfunction

    always_comb begin
        nxt    = st;
        launch = '0;
        ctl    = '0;
        if (wr_evt) begin
            nxt = SQ_IDLE;
            if (busy) begin
                if (busy_kind == OP_SECT || busy_kind == OP_BLK) begin
                    if (!suspended && cmd == C_SUSPEND) ctl.suspend = 1'b1;
                    else if (suspended && cmd == C_RESUME) ctl.resume = 1'b1;
                end
            end else begin
                unique case (st)
                    SQ_IDLE: begin
                        if (cmd == C_UNLOCK1 && at_a) nxt = SQ_U1;
                        else if (cmd == C_EXIT) ctl.exit_modes = 1'b1;
                    end
                    SQ_U1: if (cmd == C_UNLOCK2 && at_b) nxt = SQ_U2;
                    SQ_U2: if (at_a) begin
                        if (cmd == C_PROGRAM)    nxt = SQ_PROG;
                        else if (cmd == C_ERASE) nxt = SQ_E3;
                        else if (cmd == C_CFI)   ctl.cfi_on = 1'b1;
                        else if (cmd == C_SECID) ctl.sec_on = 1'b1;
                    end
                    SQ_PROG: begin
                        launch.valid = !guarded(wr_addr, wp_n);
                        launch.kind  = OP_PROG;
                        launch.addr  = wr_addr;
                        launch.data  = wr_data;
                        launch.banks = bank_of(wr_addr);
                    end
                    SQ_E3: if (cmd == C_UNLOCK1 && at_a) nxt = SQ_E4;
                    SQ_E4: if (cmd == C_UNLOCK2 && at_b) nxt = SQ_E5;
                    SQ_E5: begin
                        if (cmd == C_SECTOR) begin
                            launch.valid = !guarded(sect_base, wp_n);
                            launch.kind  = OP_SECT;
                            launch.addr  = sect_base;
                            launch.banks = bank_of(sect_base);
                        end else if (cmd == C_BLOCK) begin
                            launch.valid = !guarded(blk_base, wp_n);
                            launch.kind  = OP_BLK;
                            launch.addr  = blk_base;
                            launch.banks = bank_of(blk_base);
                        end else if (cmd == C_CHIP && at_a) begin
                            launch.valid = wp_n;
                            launch.kind  = OP_CHIP;
                            launch.banks = 2'b11;
                        end
                    end
                    default: nxt = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= nxt;
    end
endmodule

// File: rtl/fcd_op_tracker.sv
module fcd_op_tracker
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  launch_t           launch,
    input  ctl_t              ctl,
    input  logic              op_done,
    output logic              start_pulse,
    output op_kind_e          start_kind,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] start_data,
    output logic [1:0]        bank_busy,
    output op_kind_e          busy_kind,
    output logic              suspend_pulse,
    output logic              resume_pulse,
    output logic              suspended,
    output logic              cfi_mode,
    output logic              secid_mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_pulse   <= 1'b0;
            start_kind    <= OP_PROG;
            start_addr    <= '0;
            start_data    <= '0;
            bank_busy     <= '0;
            busy_kind     <= OP_PROG;
            suspend_pulse <= 1'b0;
            resume_pulse  <= 1'b0;
            suspended     <= 1'b0;
            cfi_mode      <= 1'b0;
            secid_mode    <= 1'b0;
        end else begin
            start_pulse   <= launch.valid;
            suspend_pulse <= ctl.suspend;
            resume_pulse  <= ctl.resume;
            if (launch.valid) begin
                start_kind <= launch.kind;
                start_addr <= launch.addr;
                start_data <= launch.data;
                bank_busy  <= launch.banks;
                busy_kind  <= launch.kind;
            end else if (op_done && !suspended) begin
                bank_busy <= '0;
            end
            if (ctl.suspend)     suspended <= 1'b1;
            else if (ctl.resume) suspended <= 1'b0;
            if (ctl.exit_modes) begin
                cfi_mode   <= 1'b0;
                secid_mode <= 1'b0;
            end else if (ctl.cfi_on) begin
                cfi_mode   <= 1'b1;
                secid_mode <= 1'b0;
            end else if (ctl.sec_on) begin
                cfi_mode   <= 1'b0;
                secid_mode <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fcd_top.sv
module fcd_top
    import fcd_pkg::*;
#(
    parameter int                SYNC_STAGES = 3,
    parameter int                KEY_W       = 11,
    parameter int                SECT_W      = 11,
    parameter int                BLK_W       = 15,
    parameter logic [ADDR_W-1:0] BANK_SPLIT  = 20'hC0000,
    parameter logic [ADDR_W-1:0] PROT_LIMIT  = 20'h02000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              we_n,
    input  logic              wp_n,
    input  logic              op_done,
    output logic              start_pulse,
    output logic [1:0]        start_kind,
    output logic [ADDR_W-1:0] start_addr,
    output logic [DATA_W-1:0] start_data,
    output logic [1:0]        bank_busy,
    output logic              suspend_pulse,
    output logic              resume_pulse,
    output logic              erase_suspended,
    output logic              cfi_mode,
    output logic              secid_mode
);
    logic              wr_evt;
    logic [ADDR_W-1:0] wr_addr;
    launch_t           launch;
    ctl_t              ctl;
    op_kind_e          kind_q, busy_kind;

    fcd_bus_capture #(.STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst(rst), .we_n(we_n), .bus_addr(bus_addr),
        .wr_evt(wr_evt), .wr_addr(wr_addr)
    );

    fcd_seq_fsm #(
        .KEY_W(KEY_W), .SECT_W(SECT_W), .BLK_W(BLK_W),
        .BANK_SPLIT(BANK_SPLIT), .PROT_LIMIT(PROT_LIMIT)
    ) u_seq (
        .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(bus_data), .wp_n(wp_n), .busy(|bank_busy),
        .busy_kind(busy_kind), .suspended(erase_suspended),
        .launch(launch), .ctl(ctl)
    );

    fcd_op_tracker u_trk (
        .clk(clk), .rst(rst), .launch(launch), .ctl(ctl), .op_done(op_done),
        .start_pulse(start_pulse), .start_kind(kind_q), .start_addr(start_addr),
        .start_data(start_data), .bank_busy(bank_busy), .busy_kind(busy_kind),
        .suspend_pulse(suspend_pulse), .resume_pulse(resume_pulse),
        .suspended(erase_suspended), .cfi_mode(cfi_mode), .secid_mode(secid_mode)
    );

    assign start_kind = kind_q;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       op_done,
    input logic       start_pulse,
    input logic [1:0] start_kind,
    input logic [1:0] bank_busy,
    input logic       suspend_pulse,
    input logic       erase_suspended,
    input logic       cfi_mode,
    input logic       secid_mode
);
    p_start_single_r1: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    p_chip_both_banks_r2: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && start_kind == 2'd3) |-> bank_busy == 2'b11);

    p_busy_on_start_r5: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> bank_busy != 2'b00);

    p_done_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (op_done && bank_busy != 2'b00 && !erase_suspended && !start_pulse) |=> bank_busy == 2'b00);

    p_no_start_when_busy_r6: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(bank_busy) == 2'b00);

    p_suspend_needs_erase_r7: assert property (@(posedge clk) disable iff (rst)
        suspend_pulse |-> (erase_suspended && bank_busy != 2'b00));

    p_modes_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(cfi_mode && secid_mode));

    p_chip_needs_wp_r11: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && start_kind == 2'd3) |-> $past(wp_n));
endmodule

bind fcd_top fcd_checker u_chk (
    .clk(clk), .rst(rst), .wp_n(wp_n), .op_done(op_done),
    .start_pulse(start_pulse), .start_kind(start_kind), .bank_busy(bank_busy),
    .suspend_pulse(suspend_pulse), .erase_suspended(erase_suspended),
    .cfi_mode(cfi_mode), .secid_mode(secid_mode)
);

// File: tb/tb_fcd_top.sv
`timescale 1ns/1ps
module tb_fcd_top;
    localparam int OP_CYCLES = 20;
    localparam int WATCHDOG  = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        we_n = 1'b1;
    logic        wp_n = 1'b1;
    logic        op_done = 1'b0;
    logic        start_pulse, suspend_pulse, resume_pulse, erase_suspended;
    logic        cfi_mode, secid_mode;
    logic [1:0]  start_kind, bank_busy;
    logic [19:0] start_addr;
    logic [15:0] start_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic        g_start, g_susp, g_res;
    logic [1:0]  g_kind;
    logic [19:0] g_addr;
    logic [15:0] g_data;

    always #2 clk = ~clk;

    fcd_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
        .we_n(we_n), .wp_n(wp_n), .op_done(op_done),
        .start_pulse(start_pulse), .start_kind(start_kind), .start_addr(start_addr),
        .start_data(start_data), .bank_busy(bank_busy), .suspend_pulse(suspend_pulse),
        .resume_pulse(resume_pulse), .erase_suspended(erase_suspended),
        .cfi_mode(cfi_mode), .secid_mode(secid_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sample();
        g_start = start_pulse; g_kind = start_kind; g_addr = start_addr;
        g_data = start_data; g_susp = suspend_pulse; g_res = resume_pulse;
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_data = d; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 sample();
        @(negedge clk);
    endtask

    task automatic wr_swap(input logic [19:0] a, input logic [19:0] a2, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_data = d; we_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_addr = a2;
        @(negedge clk); we_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 sample();
        @(negedge clk);
    endtask

    task automatic prefix(input logic [15:0] hi);
        wr(20'h00555, hi | 16'h00AA);
        wr(20'h002AA, hi | 16'h0055);
    endtask

    task automatic prog(input logic [19:0] a, input logic [15:0] d);
        prefix(16'h0000);
        wr(20'h00555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase(input logic [7:0] c, input logic [19:0] a);
        prefix(16'h0000);
        wr(20'h00555, 16'h0080);
        prefix(16'h0000);
        wr(a, {8'h00, c});
    endtask

    task automatic finish_op(input string tag);
        repeat (OP_CYCLES) @(negedge clk);
        chk(bank_busy != 2'b00, {tag, " busy held before done"}, bank_busy, 2'b11);
        op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        chk(bank_busy == 2'b00, {tag, " busy cleared by done"}, bank_busy, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        chk(start_pulse == 0 && bank_busy == 0 && !erase_suspended && !cfi_mode && !secid_mode,
            "R12 reset state", {start_pulse, bank_busy, erase_suspended, cfi_mode, secid_mode}, 0);
    endtask

    task automatic t_program();
        prefix(16'h0000);
        wr(20'h7D555, 16'h00A0);
        wr(20'h12345, 16'hBEEF);
        chk(g_start == 1 && g_kind == 0, "R1 program start/kind", {g_start, g_kind}, 3'b100);
        chk(g_addr == 20'h12345 && g_data == 16'hBEEF, "R1 program addr/data", {g_addr, g_data}, {20'h12345, 16'hBEEF});
        chk(bank_busy == 2'b01, "R5 program bank 1 busy", bank_busy, 2'b01);
        @(posedge clk); #1;
        chk(start_pulse == 0, "R4 start pulse one cycle", start_pulse, 0);
        wr(20'h00000, 16'h00B0);
        chk(!g_susp && !erase_suspended, "R6 suspend ignored in program", {g_susp, erase_suspended}, 0);
        prog(20'hD0000, 16'h1111);
        chk(!g_start && bank_busy == 2'b01, "R6 program dropped while busy", {g_start, bank_busy}, 2'b01);
        finish_op("R5 program");
    endtask

    task automatic t_sector_suspend();
        prefix(16'h1200);
        wr(20'h00555, 16'hFF80);
        prefix(16'h3400);
        wr(20'hD1234, 16'hA530);
        chk(g_start && g_kind == 1 && g_addr == 20'hD1000, "R2 R9 sector erase aligned",
            {g_start, g_kind, g_addr}, {1'b1, 2'd1, 20'hD1000});
        chk(bank_busy == 2'b10, "R5 sector bank 2 busy", bank_busy, 2'b10);
        wr(20'h45678, 16'h00B0);
        chk(g_susp && erase_suspended, "R7 suspend accepted", {g_susp, erase_suspended}, 2'b11);
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        chk(bank_busy == 2'b10, "R7 done ignored while suspended", bank_busy, 2'b10);
        prog(20'h30000, 16'h2222);
        chk(!g_start, "R7 other command dropped during erase", g_start, 0);
        wr(20'h00001, 16'h0030);
        chk(g_res && !erase_suspended, "R7 resume accepted", {g_res, erase_suspended}, 2'b10);
        finish_op("R5 sector");
    endtask

    task automatic t_block_chip();
        erase(8'h50, 20'h2ABCD);
        chk(g_start && g_kind == 2 && g_addr == 20'h28000, "R2 block erase aligned",
            {g_start, g_kind, g_addr}, {1'b1, 2'd2, 20'h28000});
        chk(bank_busy == 2'b01, "R5 block bank 1 busy", bank_busy, 2'b01);
        finish_op("R5 block");
        erase(8'h10, 20'h80555);
        chk(g_start && g_kind == 3 && g_addr == 0 && bank_busy == 2'b11, "R2 chip erase",
            {g_start, g_kind, g_addr, bank_busy}, {1'b1, 2'd3, 20'h0, 2'b11});
        wr(20'h00000, 16'h00B0);
        chk(!g_susp && !erase_suspended, "R6 suspend ignored in chip erase", {g_susp, erase_suspended}, 0);
        finish_op("R5 chip");
        erase(8'h10, 20'h80123);
        chk(!g_start, "R2 chip erase needs key 555", g_start, 0);
    endtask

    task automatic t_abort();
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h0054);
        wr(20'h00555, 16'h00A0);
        wr(20'h01000, 16'h1111);
        chk(!g_start && bank_busy == 0, "R8 bad unlock aborts", {g_start, bank_busy}, 0);
        prefix(16'h0000);
        wr(20'h00444, 16'h0080);
        prefix(16'h0000);
        wr(20'h40000, 16'h0030);
        chk(!g_start, "R8 misplaced erase command aborts", g_start, 0);
    endtask

    task automatic t_modes();
        prefix(16'h0000);
        wr(20'h00555, 16'h0098);
        chk(cfi_mode && !secid_mode, "R10 query mode entry", {cfi_mode, secid_mode}, 2'b10);
        prefix(16'h0000);
        wr(20'h00555, 16'hEE88);
        chk(!cfi_mode && secid_mode, "R10 id mode replaces query", {cfi_mode, secid_mode}, 2'b01);
        prog(20'h50000, 16'h0F0F);
        wr(20'h00003, 16'h00F0);
        chk(cfi_mode == 0 && secid_mode == 1, "R6 exit ignored while busy", {cfi_mode, secid_mode}, 2'b01);
        finish_op("R5 mode program");
        wr(20'h00003, 16'h00F0);
        chk(!cfi_mode && !secid_mode, "R10 exit clears modes", {cfi_mode, secid_mode}, 0);
    endtask

    task automatic t_protect();
        wp_n = 1'b0;
        erase(8'h10, 20'h00555);
        chk(!g_start && bank_busy == 0, "R11 chip erase blocked", {g_start, bank_busy}, 0);
        prog(20'h01000, 16'h3333);
        chk(!g_start, "R11 program in region blocked", g_start, 0);
        erase(8'h30, 20'h01800);
        chk(!g_start, "R11 sector in region blocked", g_start, 0);
        erase(8'h50, 20'h07000);
        chk(!g_start, "R11 block overlapping region blocked", g_start, 0);
        prog(20'h02000, 16'h4444);
        chk(g_start && g_addr == 20'h02000, "R11 program above region allowed", {g_start, g_addr}, {1'b1, 20'h02000});
        finish_op("R11 protect");
        wp_n = 1'b1;
    endtask

    task automatic t_latch();
        prefix(16'h0000);
        wr(20'h00555, 16'h00A0);
        wr_swap(20'h30000, 20'h3FFFF, 16'h5A5A);
        chk(g_start && g_addr == 20'h30000, "R3 address from falling strobe", g_addr, 20'h30000);
        finish_op("R3 latch");
    endtask

    task automatic t_reset_mid();
        erase(8'h30, 20'h60000);
        wr(20'h00000, 16'h00B0);
        chk(erase_suspended && bank_busy == 2'b01, "R12 setup suspended erase", {erase_suspended, bank_busy}, 3'b101);
        prefix(16'h0000);
        do_reset();
        #1;
        chk(bank_busy == 0 && !erase_suspended, "R12 reset ends operation", {bank_busy, erase_suspended}, 0);
        wr(20'h00555, 16'h00A0);
        wr(20'h05000, 16'h6666);
        chk(!g_start, "R12 reset drops partial sequence", g_start, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_sector_suspend();
        t_block_chip();
        t_abort();
        t_modes();
        t_protect();
        t_latch();
        t_reset_mid();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule